// File: doc/BRIEF.md
# Prioritised Interrupt Distributor with Claim/Complete

This block gathers level-sensitive interrupt requests from a set of peripheral sources and presents them to a small number of processor contexts. Every source has a small priority value. Every context has its own set of enable bits, a priority threshold and a claim/complete register. A per-context interrupt line tells the context that at least one source is eligible for it. Source number 0 is reserved and never interrupts.

Software on a context reads its claim register to take ownership of the best eligible source. The read returns that source number and clears its pending state. The source's gateway then stays blocked until software writes the same number back to the claim register as a complete. To drain all work, software reads the claim register repeatedly until it returns 0.

The register port is a plain 32-bit bus. A request is a one-cycle `req_valid` strobe with a write flag, a byte address and write data. There is no back-pressure: every request is accepted in the cycle it is presented. Each read produces `rsp_valid` and `rsp_data` exactly one cycle later, and a write produces no response. The interrupt lines are plain level outputs.

Top module: `plic_top`

## Requirements
- R1: Source number 0 does not exist. Its priority word reads as 0 and ignores writes, and a claim read returns 0 when no source is eligible for that context.
- R2: Every read is answered with `rsp_valid` high exactly one cycle after the request. Reads of unmapped or unaligned addresses return 0, and writes to them change nothing.
- R3: The priority of source n is at byte address 4*n. Only the low 3 bits are stored, and the upper bits read back as 0.
- R4: A source is eligible for context c only when it is pending, enabled for c, and its priority is strictly greater than c's threshold. A threshold of 7 blocks every source, and a priority of 0 never interrupts.
- R5: The enable bits of context c are at 0x2000 + 0x80*c. Source id is bit id%32 of word id/32, and bit 0 always reads 0.
- R6: The threshold of context c is at 0x200000 + 0x1000*c and the claim register is 4 bytes above it. A claim read returns the eligible source with the highest priority (the lower id wins a tie) and clears that source's pending state.
- R7: A claimed source raises no new request until it is completed. After a complete, a request that is still high becomes pending again.
- R8: A complete write is ignored if the written id is not currently claimed, or if that source is not enabled for the context written to.
- R9: Each context's interrupt output is registered. It reflects the eligibility of the state one cycle after that state changes.
- R10: Repeated claim reads hand out the eligible sources one by one in priority order, and then return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | Level request per source; bit 0 is unused |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
Two sources with equal priority are raised together, so the claim order must show the lower id first; a design that compared with greater-or-equal would hand out the higher id first. Sources are held high across claim and complete, so a missing gateway block shows up as a repeated claim of the same source, and a missing re-arm shows up as a 0. A complete is written through a context that has that source disabled, and a design that skipped the enable check would re-pend the source there. A threshold exactly equal to the priority must block delivery, and the interrupt line is sampled in both the cycle before and the cycle after an enable write, to catch a line that is combinational or late by a cycle.

// File: rtl/plic_pkg.sv
package plic_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned OFS_THR    = 32'h0;
  localparam int unsigned OFS_CLAIM  = 32'h4;
endpackage

// File: rtl/plic_decode.sv
module plic_decode
  import plic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 22,
  localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int NWORDS = (NSRC + 31) / 32
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CTX_W-1:0]  ctx,
  output logic [15:0]       index
);
  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a     = 32'(addr);
    kind  = RK_NONE;
    ctx   = '0;
    index = '0;
    off   = '0;
    if (a[1:0] == 2'b00) begin
      if (a < EN_BASE) begin
        if ((a >> 2) < 32'(NSRC) && (a >> 2) != 0) begin
          kind  = RK_PRIO;
          index = 16'(a >> 2);
        end
      end else if (a < EN_BASE + EN_STRIDE * 32'(NCTX)) begin
        off = a - EN_BASE;
        if (((off % EN_STRIDE) >> 2) < 32'(NWORDS)) begin
          kind  = RK_EN;
          ctx   = CTX_W'(off / EN_STRIDE);
          index = 16'((off % EN_STRIDE) >> 2);
        end
      end else if (a >= CTX_BASE && a < CTX_BASE + CTX_STRIDE * 32'(NCTX)) begin
        off = a - CTX_BASE;
        ctx = CTX_W'(off / CTX_STRIDE);
        if ((off % CTX_STRIDE) == OFS_THR)        kind = RK_THR;
        else if ((off % CTX_STRIDE) == OFS_CLAIM) kind = RK_CLAIM;
      end
    end
  end
endmodule

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      if (claim_i) begin
        pending_o <= 1'b0;
        busy_o    <= 1'b1;
      end else begin
        if (complete_i) busy_o <= 1'b0;
        if (level_in && !busy_o && !pending_o) pending_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/plic_pick.sv
module plic_pick #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             pending,
  input  logic [NSRC-1:0]             enable,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]           thr,
  output logic [ID_W-1:0]             best_id,
  output logic                        any_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (pending[i] && enable[i] && prio[i] > thr && prio[i] > best_p) begin
        best_p  = prio[i];
        best_id = ID_W'(i);
      end
    end
    any_o = (best_id != '0);
  end
endmodule

// File: rtl/plic_top.sv
module plic_top
  import plic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W  = $clog2(NSRC);
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC-1:0]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NSRC-1:0]             pend_w;
  logic [NSRC-1:0]             busy_w;
  logic [NSRC-1:0]             claim_vec;
  logic [NSRC-1:0]             cmp_vec;
  logic [NCTX-1:0][ID_W-1:0]   best_id;
  logic [NCTX-1:0]             elig_any;

  reg_kind_e        kind;
  logic [CTX_W-1:0] dctx;
  logic [15:0]      didx;
  logic             rd_en;
  logic             wr_en;
  logic             claim_rd;
  logic [31:0]      rd_next;

  plic_decode #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .kind(kind), .ctx(dctx), .index(didx)
  );

  assign rd_en    = req_valid && !req_write;
  assign wr_en    = req_valid && req_write;
  assign claim_rd = rd_en && kind == RK_CLAIM;

  assign pend_w[0]    = 1'b0;
  assign busy_w[0]    = 1'b0;
  assign claim_vec[0] = 1'b0;
  assign cmp_vec[0]   = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    assign claim_vec[i] = claim_rd && best_id[dctx] == ID_W'(i);
    assign cmp_vec[i]   = wr_en && kind == RK_CLAIM && req_wdata == 32'(i)
                          && busy_w[i] && en_q[dctx][i];
    plic_gateway u_gw (
      .clk(clk), .rst_n(rst_n), .level_in(src_irq[i]),
      .claim_i(claim_vec[i]), .complete_i(cmp_vec[i]),
      .pending_o(pend_w[i]), .busy_o(busy_w[i])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    plic_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
      .pending(pend_w), .enable(en_q[c]), .prio(prio_q), .thr(thr_q[c]),
      .best_id(best_id[c]), .any_o(elig_any[c])
    );
  end

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en) begin
      case (kind)
        RK_PRIO: prio_q[didx[ID_W-1:0]] <= req_wdata[PRIO_W-1:0];
        RK_THR:  thr_q[dctx] <= req_wdata[PRIO_W-1:0];
        RK_EN: begin
          for (int b = 1; b < NSRC; b++) begin
            if (32'(b / 32) == 32'(didx)) en_q[dctx][b] <= req_wdata[b % 32];
          end
        end
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_next = '0;
    case (kind)
      RK_PRIO:  rd_next = 32'(prio_q[didx[ID_W-1:0]]);
      RK_THR:   rd_next = 32'(thr_q[dctx]);
      RK_CLAIM: rd_next = 32'(best_id[dctx]);
      RK_EN: begin
        for (int b = 1; b < NSRC; b++) begin
          if (32'(b / 32) == 32'(didx)) rd_next[b % 32] = en_q[dctx][b];
        end
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      irq_o     <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_data  <= rd_en ? rd_next : '0;
      irq_o     <= elig_any;
    end
  end
endmodule

// File: rtl/plic_top_checker.sv
module plic_top_checker #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic                        rsp_valid,
  input logic [31:0]                 rsp_data,
  input logic [NCTX-1:0]             irq_o,
  input logic [NSRC-1:0]             pending,
  input logic [NSRC-1:0]             busy,
  input logic [NSRC-1:0][PRIO_W-1:0] prio,
  input logic [NCTX-1:0][PRIO_W-1:0] thr,
  input logic                        claim_rd
);
  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_pend_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & busy) == '0);

  assert_claim_marks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(claim_rd) && rsp_data != 0) |-> busy[rsp_data[ID_W-1:0]]);

  for (genvar c = 0; c < NCTX; c++) begin : g_c
    assert_thr_max_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(thr[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]);
  end

  for (genvar i = 1; i < NSRC; i++) begin : g_s
    assert_prio_zero_never_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[i]) |-> $past(prio[i]) != '0);
  end
endmodule

bind plic_top plic_top_checker #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o),
  .pending(pend_w), .busy(busy_w), .prio(prio_q), .thr(thr_q), .claim_rd(claim_rd)
);

// File: tb/plic_top_test.sv
module plic_top_test;
  localparam int NSRC = 32;
  localparam int NCTX = 2;
  localparam int AW   = 22;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_irq = '0;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_data;
  logic [NCTX-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  plic_top #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] a_prio(int id); return AW'(4 * id); endfunction
  function automatic logic [AW-1:0] a_en(int c);    return AW'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [AW-1:0] a_thr(int c);   return AW'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [AW-1:0] a_clm(int c);   return AW'(32'h200004 + 32'h1000 * c); endfunction

  // Monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual %h expected none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_irq(int c, logic e, string t);
    checks++;
    if (irq_o[c] !== e) begin
      errors++;
      $display("FAIL %s: irq_o[%0d] actual %b expected %b", t, c, irq_o[c], e);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    chk_irq(0, 1'b0, "R9 reset irq0");
    chk_irq(1, 1'b0, "R9 reset irq1");
    rd(a_clm(0), 0, "R1 empty claim");
    rd(a_prio(0), 0, "R1 id0 priority");
    wr(a_prio(0), 5);
    rd(a_prio(0), 0, "R1 id0 priority write ignored");

    wr(a_prio(5), 32'hFFFF_FFFF);
    rd(a_prio(5), 7, "R3 priority width");
    wr(a_prio(5), 3);
    wr(a_prio(9), 3);
    wr(a_prio(12), 6);
    rd(a_prio(9), 3, "R3 priority readback");

    wr(22'h100000, 32'h1234);
    rd(22'h100000, 0, "R2 unmapped read");
    rd(a_thr(0) + 22'h2, 0, "R2 unaligned read");

    wr(a_en(0), 32'h0000_1221);
    rd(a_en(0), 32'h0000_1220, "R5 enable word ctx0 bit0 zero");
    wr(a_en(1), 32'h0000_0200);
    rd(a_en(1), 32'h0000_0200, "R5 enable word ctx1");

    // Tie: 5 and 9 equal priority
    @(negedge clk);
    src_irq[5] = 1'b1; src_irq[9] = 1'b1;
    wait_cyc(2);
    chk_irq(0, 1'b1, "R4 eligible ctx0");
    chk_irq(1, 1'b1, "R4 eligible ctx1");
    rd(a_clm(0), 5, "R6 tie lower id first");
    rd(a_clm(0), 9, "R10 drain second");
    rd(a_clm(0), 0, "R10 drain empty");
    wait_cyc(1);
    chk_irq(0, 1'b0, "R7 claimed held sources silent");
    rd(a_clm(1), 0, "R7 claimed source not re-pending");

    // Ignored completes
    wr(a_clm(1), 5);
    wait_cyc(2);
    rd(a_clm(0), 0, "R8 complete via disabled context ignored");

    // Complete with level still high re-pends
    wr(a_clm(0), 5);
    wait_cyc(2);
    rd(a_clm(0), 5, "R7 re-pend after complete");
    @(negedge clk);
    src_irq[5] = 1'b0;
    wr(a_clm(0), 5);
    wait_cyc(2);
    rd(a_clm(0), 0, "R7 no re-pend after drop");
    wr(a_clm(0), 9);
    wait_cyc(2);
    rd(a_clm(0), 9, "R7 re-pend id9");

    // Threshold equal to priority blocks
    wr(a_thr(0), 3);
    rd(a_thr(0), 3, "R6 threshold readback");
    wr(a_clm(0), 9);
    wait_cyc(2);
    chk_irq(0, 1'b0, "R4 threshold equal blocks");
    chk_irq(1, 1'b1, "R4 other context still eligible");
    rd(a_clm(0), 0, "R4 claim blocked by threshold");
    rd(a_clm(1), 9, "R6 claim via ctx1");

    wr(a_prio(12), 7);
    wr(a_thr(0), 7);
    @(negedge clk);
    src_irq[12] = 1'b1;
    wait_cyc(2);
    chk_irq(0, 1'b0, "R4 threshold 7 masks");
    rd(a_clm(0), 0, "R4 threshold 7 claim empty");
    wr(a_thr(0), 6);
    wait_cyc(1);
    chk_irq(0, 1'b1, "R4 priority above threshold");
    rd(a_clm(0), 12, "R6 claim id12");

    // Priority order
    wr(a_clm(0), 12);
    wr(a_clm(1), 9);
    wr(a_thr(0), 0);
    wait_cyc(2);
    rd(a_clm(0), 12, "R6 higher priority first");
    rd(a_clm(0), 9, "R10 drain lower priority next");
    rd(a_clm(0), 0, "R10 drain ends with 0");

    // Priority 0 never interrupts
    wr(a_prio(5), 0);
    @(negedge clk);
    src_irq[5] = 1'b1;
    wait_cyc(2);
    chk_irq(0, 1'b0, "R4 priority 0 no irq");
    rd(a_clm(0), 0, "R4 priority 0 not claimable");

    // Output timing
    wr(a_prio(20), 2);
    @(negedge clk);
    src_irq[20] = 1'b1;
    wait_cyc(2);
    chk_irq(0, 1'b0, "R4 disabled source silent");
    wr(a_en(0), 32'h0010_1220);
    chk_irq(0, 1'b0, "R9 irq not combinational");
    wait_cyc(1);
    chk_irq(0, 1'b1, "R9 irq one cycle later");
    rd(a_clm(0), 20, "R6 claim id20");

    wait_cyc(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule